// File: doc/BRIEF.md
# Display Timing Generator with External Lock

This block produces the horizontal and vertical timing of a raster pixel output port. Two counters walk through each line and each frame. The line runs through sync, back porch, active video and front porch. The frame runs through sync lines, back-porch lines, active lines and front-porch lines. From these counters the block derives a blanking signal and two sync signals. Each of these is registered onto the output pins with a polarity that software selects.

A five-bit mode register sets how the timing leaves the block. In driving mode the block enables its sync outputs. In following mode it leaves them tri-stated and watches the incoming syncs. Each incoming active edge pulls the matching counter back to the start of its period, which locks the block to an external timing source. The horizontal pin can also carry a composite sync. Finally, the pixel stream can carry in-band timing reference words: a start-of-line code before active video and an end-of-line code after it.

Top module: `vsg_top`

## Requirements
- R1: The mode register is five bits wide and reads back what was last written. It is written on a clock with `ctrl_we` high and reads zero after reset. Bit 4 inverts blank, bit 3 inverts both syncs, bit 2 selects composite sync, bit 1 selects driving mode, and bit 0 enables reference codes.
- R2: `hs_oe` and `vs_oe` follow mode bit 1 one clock after the register takes the new value. Both are low during and after reset.
- R3: A line lasts H_SYNC+H_BP+H_ACTIVE+H_FP clocks. Horizontal sync is active for the first H_SYNC counts. Active video spans counts H_SYNC+H_BP up to, but not including, H_SYNC+H_BP+H_ACTIVE. Every output is registered one clock after the counter state it reflects.
- R4: A frame lasts V_SYNC+V_BP+V_ACTIVE+V_FP lines. Vertical sync is active in the first V_SYNC lines, and active lines start after V_SYNC+V_BP lines.
- R5: `blank_o` is asserted outside active video, in both horizontal and vertical blanking. It is active high when bit 4 is clear and active low when bit 4 is set.
- R6: Both sync outputs are active high when bit 3 is clear and active low when bit 3 is set.
- R7: When bit 2 is set, `hs_o` carries the OR of horizontal and vertical sync, with the polarity applied after the OR. `vs_o` still carries vertical sync alone.
- R8: In following mode, an incoming horizontal sync is sampled through two registers after the polarity is applied. Its active edge resets the horizontal counter and advances the line counter. With `hs_i` first seen active at clock edge E, output reflects horizontal count 0 after edge E+2.
- R9: In following mode, an active edge of the incoming vertical sync, detected the same way, resets the line counter to 0 and toggles the field flag.
- R10: In driving mode, `hs_i` and `vs_i` have no effect on any output.
- R11: With bit 0 set, the pixel output carries FF, 00, 00, XY. The start code occupies the four clocks before active video, with H=0. The end code occupies the four clocks after active video, with H=1. XY has bit7=1, bit6=field, bit5=vertical blank, bit4=H, bit3=V^H, bit2=F^H, bit1=F^V and bit0=F^V^H.
- R12: The field flag starts at 0 and toggles at every frame start.
- R13: During active video `pix_o` carries `pix_i` delayed by one clock. Elsewhere, outside any code words, it carries 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Mode register write strobe |
| ctrl_wdata | input | 5 | Mode register write value |
| ctrl_rdata | output | 5 | Mode register read value |
| hs_i | input | 1 | Incoming horizontal sync pin level |
| vs_i | input | 1 | Incoming vertical sync pin level |
| hs_o | output | 1 | Horizontal or composite sync out |
| hs_oe | output | 1 | Output enable for horizontal pin |
| vs_o | output | 1 | Vertical sync out |
| vs_oe | output | 1 | Output enable for vertical pin |
| blank_o | output | 1 | Blanking indicator |
| pix_i | input | 8 | Pixel data in |
| pix_o | output | 8 | Pixel data out with optional codes |

## Verification
Sync, blank and pixel outputs are due one clock after the counter state they encode. Pixel data is due one clock after it is presented, and an output enable is due one clock after the register write lands. The incoming-sync lock shows two clocks after the first sampling edge. The bench model steps at every rising edge with exactly these delays. All outputs are compared at the following falling edge, away from the edges where they change. Directed checks count edges explicitly: they look at the falling edge just before and just after a change is due.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int PIX_W = 8;
    localparam logic [PIX_W-1:0] BLANK_LEVEL = 8'h10;

    // field order matches register bit positions 4..0
    typedef struct packed {
        logic blank_inv;
        logic sync_inv;
        logic comp;
        logic master;
        logic ccir;
    } vsg_ctrl_t;

    typedef enum logic [1:0] {
        CODE_NONE = 2'd0,
        CODE_SAV  = 2'd1,
        CODE_EAV  = 2'd2
    } code_kind_e;

    typedef struct packed {
        logic       hsync;
        logic       vsync;
        logic       hblank;
        logic       vblank;
        logic       field;
        code_kind_e kind;
        logic [1:0] idx;
    } vsg_tim_t;

    function automatic logic [PIX_W-1:0] xy_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [PIX_W-1:0] code_word(input vsg_tim_t t);
        case (t.idx)
            2'd0:    return '1;
            2'd3:    return xy_word(t.field, t.vblank, t.kind == CODE_EAV);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/vsg_timing.sv
module vsg_timing
    import vsg_pkg::*;
#(
    parameter int H_SYNC   = 4,
    parameter int H_BP     = 8,
    parameter int H_ACTIVE = 16,
    parameter int H_FP     = 6,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 2,
    parameter int V_ACTIVE = 6,
    parameter int V_FP     = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     slave_i,
    input  logic     hs_act_i,
    input  logic     vs_act_i,
    output vsg_tim_t tim_o
);
    localparam int H_TOTAL = H_SYNC + H_BP + H_ACTIVE + H_FP;
    localparam int V_TOTAL = V_SYNC + V_BP + V_ACTIVE + V_FP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);
    localparam int H_ACT0  = H_SYNC + H_BP;
    localparam int H_ACT1  = H_ACT0 + H_ACTIVE;
    localparam int V_ACT0  = V_SYNC + V_BP;
    localparam int V_ACT1  = V_ACT0 + V_ACTIVE;

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          field_q;
    logic          hs_s1, hs_s2, vs_s1, vs_s2;
    logic          hs_edge, vs_edge, h_last, line_start;
    int            hp, vp;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_s1 <= 1'b0;
            hs_s2 <= 1'b0;
            vs_s1 <= 1'b0;
            vs_s2 <= 1'b0;
        end else begin
            hs_s1 <= hs_act_i;
            hs_s2 <= hs_s1;
            vs_s1 <= vs_act_i;
            vs_s2 <= vs_s1;
        end
    end

    assign hs_edge    = slave_i & hs_s1 & ~hs_s2;
    assign vs_edge    = slave_i & vs_s1 & ~vs_s2;
    assign h_last     = (int'(h_cnt) == H_TOTAL - 1);
    assign line_start = hs_edge | h_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt   <= '0;
            v_cnt   <= '0;
            field_q <= 1'b0;
        end else begin
            h_cnt <= line_start ? '0 : h_cnt + HW'(1);
            if (vs_edge) begin
                v_cnt   <= '0;
                field_q <= ~field_q;
            end else if (line_start) begin
                if (int'(v_cnt) == V_TOTAL - 1) begin
                    v_cnt   <= '0;
                    field_q <= ~field_q;
                end else begin
                    v_cnt <= v_cnt + VW'(1);
                end
            end
        end
    end

    always_comb begin
        hp           = int'(h_cnt);
        vp           = int'(v_cnt);
        tim_o.hsync  = hp < H_SYNC;
        tim_o.vsync  = vp < V_SYNC;
        tim_o.hblank = !(hp >= H_ACT0 && hp < H_ACT1);
        tim_o.vblank = !(vp >= V_ACT0 && vp < V_ACT1);
        tim_o.field  = field_q;
        tim_o.kind   = CODE_NONE;
        tim_o.idx    = 2'd0;
        if (hp >= H_ACT0 - 4 && hp < H_ACT0) begin
            tim_o.kind = CODE_SAV;
            tim_o.idx  = 2'(hp - (H_ACT0 - 4));
        end else if (hp >= H_ACT1 && hp < H_ACT1 + 4) begin
            tim_o.kind = CODE_EAV;
            tim_o.idx  = 2'(hp - H_ACT1);
        end
    end

    AST_H_WRAP: assert property (@(posedge clk) disable iff (rst) (h_last && !hs_edge) |=> (h_cnt == '0)); // R3
    AST_H_LOCK: assert property (@(posedge clk) disable iff (rst) hs_edge |=> (h_cnt == '0)); // R8
    AST_V_LOCK: assert property (@(posedge clk) disable iff (rst) vs_edge |=> (v_cnt == '0 && field_q != $past(field_q))); // R9
    AST_V_RANGE: assert property (@(posedge clk) disable iff (rst) int'(v_cnt) < V_TOTAL); // R4

endmodule

// File: rtl/vsg_sync_out.sv
module vsg_sync_out
    import vsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  vsg_tim_t  tim_i,
    input  vsg_ctrl_t ctrl_i,
    output logic      hs_o,
    output logic      vs_o,
    output logic      blank_o,
    output logic      hs_oe,
    output logic      vs_oe
);
    logic hs_raw;

    assign hs_raw = ctrl_i.comp ? (tim_i.hsync | tim_i.vsync) : tim_i.hsync;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_o    <= 1'b0;
            vs_o    <= 1'b0;
            blank_o <= 1'b0;
            hs_oe   <= 1'b0;
            vs_oe   <= 1'b0;
        end else begin
            hs_o    <= hs_raw ^ ctrl_i.sync_inv;
            vs_o    <= tim_i.vsync ^ ctrl_i.sync_inv;
            blank_o <= (tim_i.hblank | tim_i.vblank) ^ ctrl_i.blank_inv;
            hs_oe   <= ctrl_i.master;
            vs_oe   <= ctrl_i.master;
        end
    end

    AST_COMP_MERGE: assert property (@(posedge clk) disable iff (rst) (ctrl_i.comp && !ctrl_i.sync_inv && tim_i.vsync) |=> hs_o); // R7
    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst) (!ctrl_i.master && $stable(ctrl_i.master)) |=> (!hs_oe && !vs_oe)); // R2
    AST_BLANK_OFF: assert property (@(posedge clk) disable iff (rst) (!ctrl_i.blank_inv && !tim_i.hblank && !tim_i.vblank) |=> !blank_o); // R5

endmodule

// File: rtl/vsg_pix_mux.sv
module vsg_pix_mux
    import vsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  vsg_tim_t         tim_i,
    input  logic             ccir_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] pix_o
);
    logic [PIX_W-1:0] pix_nxt;

    always_comb begin
        if (ccir_i && tim_i.kind != CODE_NONE)
            pix_nxt = code_word(tim_i);
        else if (!tim_i.hblank && !tim_i.vblank)
            pix_nxt = pix_i;
        else
            pix_nxt = BLANK_LEVEL;
    end

    always_ff @(posedge clk) begin
        if (rst) pix_o <= '0;
        else     pix_o <= pix_nxt;
    end

    AST_CODE_HEAD: assert property (@(posedge clk) disable iff (rst) (ccir_i && tim_i.kind == CODE_EAV && tim_i.idx == 2'd0) |=> (pix_o == '1)); // R11
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst) (!tim_i.hblank && !tim_i.vblank) |=> (pix_o == $past(pix_i))); // R13

endmodule

// File: rtl/vsg_top.sv
module vsg_top
    import vsg_pkg::*;
#(
    parameter int H_SYNC   = 4,
    parameter int H_BP     = 8,
    parameter int H_ACTIVE = 16,
    parameter int H_FP     = 6,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 2,
    parameter int V_ACTIVE = 6,
    parameter int V_FP     = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [4:0]       ctrl_wdata,
    output logic [4:0]       ctrl_rdata,
    input  logic             hs_i,
    input  logic             vs_i,
    output logic             hs_o,
    output logic             hs_oe,
    output logic             vs_o,
    output logic             vs_oe,
    output logic             blank_o,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] pix_o
);
    vsg_ctrl_t ctrl_q;
    vsg_tim_t  tim;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= vsg_ctrl_t'(ctrl_wdata);
    end

    assign ctrl_rdata = ctrl_q;

    vsg_timing #(
        .H_SYNC(H_SYNC), .H_BP(H_BP), .H_ACTIVE(H_ACTIVE), .H_FP(H_FP),
        .V_SYNC(V_SYNC), .V_BP(V_BP), .V_ACTIVE(V_ACTIVE), .V_FP(V_FP)
    ) u_timing (
        .clk      (clk),
        .rst      (rst),
        .slave_i  (~ctrl_q.master),
        .hs_act_i (hs_i ^ ctrl_q.sync_inv),
        .vs_act_i (vs_i ^ ctrl_q.sync_inv),
        .tim_o    (tim)
    );

    vsg_sync_out u_sync (
        .clk     (clk),
        .rst     (rst),
        .tim_i   (tim),
        .ctrl_i  (ctrl_q),
        .hs_o    (hs_o),
        .vs_o    (vs_o),
        .blank_o (blank_o),
        .hs_oe   (hs_oe),
        .vs_oe   (vs_oe)
    );

    vsg_pix_mux u_pix (
        .clk    (clk),
        .rst    (rst),
        .tim_i  (tim),
        .ccir_i (ctrl_q.ccir),
        .pix_i  (pix_i),
        .pix_o  (pix_o)
    );

    AST_CTRL_STORE: assert property (@(posedge clk) disable iff (rst) ctrl_we |=> (ctrl_rdata == $past(ctrl_wdata))); // R1

endmodule

// File: tb/test_vsg_top.sv
module test_vsg_top;
    localparam int H_SYNC = 4, H_BP = 8, H_ACTIVE = 16, H_FP = 6;
    localparam int V_SYNC = 2, V_BP = 2, V_ACTIVE = 6, V_FP = 1;
    localparam int H_TOT = H_SYNC + H_BP + H_ACTIVE + H_FP;
    localparam int V_TOT = V_SYNC + V_BP + V_ACTIVE + V_FP;
    localparam int A0 = H_SYNC + H_BP, A1 = A0 + H_ACTIVE;
    localparam int VA0 = V_SYNC + V_BP, VA1 = VA0 + V_ACTIVE;

    logic clk = 1'b0, rst = 1'b1, ctrl_we = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
    logic [4:0] ctrl_wdata = '0, ctrl_rdata;
    logic hs_o, hs_oe, vs_o, vs_oe, blank_o;
    logic [7:0] pix_i = '0, pix_o;

    int n_checks = 0, n_fails = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    string phase = "init";

    // reference model state
    int mh, mv;
    logic mf, ms1, ms2, mt1, mt2, he, ve, ls;
    logic [4:0] mctrl;
    logic e_hs, e_vs, e_bl, e_hoe, e_voe;
    logic [7:0] e_pix;

    always #10 clk = ~clk;

    vsg_top #(
        .H_SYNC(H_SYNC), .H_BP(H_BP), .H_ACTIVE(H_ACTIVE), .H_FP(H_FP),
        .V_SYNC(V_SYNC), .V_BP(V_BP), .V_ACTIVE(V_ACTIVE), .V_FP(V_FP)
    ) i_vsg_top (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .hs_i(hs_i), .vs_i(vs_i), .hs_o(hs_o),
        .hs_oe(hs_oe), .vs_o(vs_o), .vs_oe(vs_oe), .blank_o(blank_o),
        .pix_i(pix_i), .pix_o(pix_o)
    );

    function automatic logic [7:0] b_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] b_pix(input int h, input int v, input logic f,
                                         input logic ccir, input logic [7:0] din);
        logic vb;
        vb = !(v >= VA0 && v < VA1);
        if (ccir && h >= A0 - 4 && h < A0)
            return (h == A0 - 4) ? 8'hFF : (h == A0 - 1) ? b_xy(f, vb, 1'b0) : 8'h00;
        if (ccir && h >= A1 && h < A1 + 4)
            return (h == A1) ? 8'hFF : (h == A1 + 3) ? b_xy(f, vb, 1'b1) : 8'h00;
        if (h >= A0 && h < A1 && !vb) return din;
        return 8'h10;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mh = 0; mv = 0; mf = 1'b0; ms1 = 0; ms2 = 0; mt1 = 0; mt2 = 0; mctrl = '0;
            e_hs = 0; e_vs = 0; e_bl = 0; e_hoe = 0; e_voe = 0; e_pix = '0;
        end else begin
            e_hs  = ((mctrl[2] ? ((mh < H_SYNC) || (mv < V_SYNC)) : (mh < H_SYNC))) ^ mctrl[3];
            e_vs  = (mv < V_SYNC) ^ mctrl[3];
            e_bl  = (!(mh >= A0 && mh < A1) || !(mv >= VA0 && mv < VA1)) ^ mctrl[4];
            e_hoe = mctrl[1];
            e_voe = mctrl[1];
            e_pix = b_pix(mh, mv, mf, mctrl[0], pix_i);
            he  = !mctrl[1] && ms1 && !ms2;
            ve  = !mctrl[1] && mt1 && !mt2;
            ms2 = ms1; ms1 = hs_i ^ mctrl[3];
            mt2 = mt1; mt1 = vs_i ^ mctrl[3];
            ls  = he || (mh == H_TOT - 1);
            if (ve) begin mv = 0; mf = !mf; end
            else if (ls) begin
                if (mv == V_TOT - 1) begin mv = 0; mf = !mf; end
                else mv = mv + 1;
            end
            mh = ls ? 0 : mh + 1;
            if (ctrl_we) mctrl = ctrl_wdata;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check(hs_o == e_hs, "R3 R6 R7 R8 R10 hs_o", hs_o, e_hs);
            check(vs_o == e_vs, "R4 R6 R9 R10 vs_o", vs_o, e_vs);
            check(blank_o == e_bl, "R5 blank_o", blank_o, e_bl);
            check(pix_o == e_pix, "R11 R12 R13 pix_o", pix_o, e_pix);
            check(hs_oe == e_hoe && vs_oe == e_voe, "R2 oe", {hs_oe, vs_oe}, {e_hoe, e_voe});
            check(ctrl_rdata == mctrl, "R1 ctrl_rdata", ctrl_rdata, mctrl);
        end
    end

    task automatic wr(input logic [4:0] val);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = val;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic run(input int n, input bit rnd_pins);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_i = 8'($urandom);
            if (rnd_pins) begin hs_i = 1'($urandom); vs_i = 1'($urandom); end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        check(ctrl_rdata == 5'd0, "R1 reset value", ctrl_rdata, 0);
        check(!hs_oe && !vs_oe, "R2 reset oe", {hs_oe, vs_oe}, 0);
        check(hs_o == 0 && vs_o == 0 && blank_o == 0 && pix_o == 0, "R3 reset outputs",
              {hs_o, vs_o, blank_o, pix_o}, 0);
        rst = 1'b0;
        cmp_en = 1'b1;

        phase = "R2 oe timing";
        wr(5'b00010);
        check(hs_oe == 1'b0, "R2 oe not yet", hs_oe, 0);
        check(ctrl_rdata == 5'b00010, "R1 readback", ctrl_rdata, 5'b00010);
        @(negedge clk);
        check(hs_oe == 1'b1 && vs_oe == 1'b1, "R2 oe set", {hs_oe, vs_oe}, 2'b11);

        phase = "R3 R4 R5 driving";
        run(2 * H_TOT * V_TOT, 1'b0);
        phase = "R10 driving, pins toggled";
        run(H_TOT * V_TOT, 1'b1);
        phase = "R7 composite";
        wr(5'b00110);
        run(H_TOT * V_TOT, 1'b0);
        phase = "R5 R6 inverted";
        wr(5'b11110);
        run(H_TOT * V_TOT, 1'b1);
        phase = "R11 R12 codes";
        wr(5'b00011);
        run(3 * H_TOT * V_TOT, 1'b0);

        phase = "R8 line lock";
        wr(5'b00000);
        hs_i = 1'b0; vs_i = 1'b0;
        repeat (3) @(negedge clk);
        hs_i = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(hs_o == 1'b1, "R8 hs after lock", hs_o, 1);
        hs_i = 1'b0;
        repeat (H_SYNC) @(posedge clk);
        @(negedge clk);
        check(hs_o == 1'b0, "R8 hs ends after sync width", hs_o, 0);

        phase = "R9 frame lock";
        repeat (5) @(negedge clk);
        vs_i = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(vs_o == 1'b1, "R9 vs after lock", vs_o, 1);
        vs_i = 1'b0;

        phase = "random";
        for (int k = 0; k < 40; k++) begin
            if ($urandom_range(0, 2) == 0) wr(5'($urandom));
            for (int j = 0; j < 100; j++) begin
                @(negedge clk);
                pix_i = 8'($urandom);
                if ($urandom_range(0, 30) == 0) hs_i = ~hs_i;
                if ($urandom_range(0, 300) == 0) vs_i = ~vs_i;
            end
        end

        done = 1'b1;
        cmp_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule